// File: doc/BRIEF.md
# Dual DMA Base Counter with Staged Byte Loading

The block keeps two independent 16-bit transfer counters, one for the playback channel and one for the capture channel. Software programs each counter through an indexed byte-wide register port. The value it writes is the number of bytes to move minus one. A write to a counter's low-byte index is held in a staging register and does not touch the counter. A write to its high-byte index joins that byte with the staged low byte and moves the whole 16-bit word into the base register and the live counter in a single clock edge.

Each transfer strobe from a channel lowers that channel's counter by one. A strobe that arrives while the counter holds zero raises a one-cycle terminal-count pulse and reloads the counter from the last loaded base. Reads at either byte index return that byte of the live count. Driver software can therefore save the exact DMA position before a power-down and restore it later by writing it back.

Top module: `dma_cnt_pair`

## Requirements
- R1: After reset, every counter byte reads back as FFh, and both terminal-count outputs are low.
- R2: A write to a low-byte index (0Bh playback, 0Dh capture) only stages the byte, and the live count read back is unchanged.
- R3: A write to a high-byte index (0Ch playback, 0Eh capture) loads {written byte, staged low byte} into both base and live count, visible at readback on the next cycle.
- R4: A transfer strobe while the count is nonzero lowers the count by exactly one.
- R5: A transfer strobe while the count is zero reloads the count from the base and drives that channel's terminal-count output high for exactly the one following cycle. Terminal count is never high without such a strobe.
- R6: When a high-byte write and a strobe on the same channel fall in one cycle, the write is applied, the strobe is discarded, and no terminal count follows.
- R7: Strobes, writes and terminal counts of one channel never alter the other channel's staging, base, count or terminal-count output.
- R8: reg_rdata is combinational from reg_addr: the low index returns count bits 7:0, the high index returns bits 15:8, and every other index returns 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 8 | Register index for reads and writes |
| reg_wr | input | 1 | Write strobe for reg_wdata at reg_addr |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Readback byte selected by reg_addr |
| play_xfer | input | 1 | One playback transfer completed this cycle |
| rec_xfer | input | 1 | One capture transfer completed this cycle |
| play_tc | output | 1 | Playback terminal-count pulse |
| rec_tc | output | 1 | Capture terminal-count pulse |

## Verification
Two functions can fall in one cycle: a high-byte load and a countdown strobe on the same channel. A directed case drives the capture high-byte write together with a capture strobe. The bench then expects the freshly loaded value unchanged and no terminal-count pulse. The random phase keeps counts near zero by loading small values, so load, decrement and wrap collide often, and after every cycle the bench compares all four readback bytes and both pulses with its own model.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  localparam byte_t BYTE_INIT = '1;
  localparam cnt_t  CNT_INIT  = '1;

  // next value after one strobe: wrap to base at zero, else step down
  function automatic cnt_t step_down(cnt_t cur, cnt_t base);
    return (cur == '0) ? base : cur - cnt_t'(1);
  endfunction

  function automatic cnt_t join_bytes(byte_t hi, byte_t lo);
    return {hi, lo};
  endfunction

  function automatic byte_t pick_byte(cnt_t cur, logic upper);
    return upper ? cur[CNT_W-1:BYTE_W] : cur[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
#(
  parameter int                ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LO_IDX = '0,
  parameter logic [ADDR_W-1:0] HI_IDX = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  byte_t             bus_wdata,
  input  logic              xfer,
  output logic              tc_o,
  output logic              rd_hit,
  output byte_t             rd_byte
);
  byte_t stage;
  cnt_t  base;
  cnt_t  count;

  // named internal events
  logic lo_sel, hi_sel, lo_wr, hi_wr, step, wrap;
  assign lo_sel = (bus_addr == LO_IDX);
  assign hi_sel = (bus_addr == HI_IDX);
  assign lo_wr  = bus_wr && lo_sel;
  assign hi_wr  = bus_wr && hi_sel;
  assign step   = xfer && !hi_wr;      // load wins over strobe
  assign wrap   = step && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= BYTE_INIT;
      base  <= CNT_INIT;
      count <= CNT_INIT;
      tc_o  <= 1'b0;
    end else begin
      tc_o <= wrap;
      if (lo_wr) stage <= bus_wdata;
      if (hi_wr) begin
        base  <= join_bytes(bus_wdata, stage);
        count <= join_bytes(bus_wdata, stage);
      end else if (step) begin
        count <= step_down(count, base);
      end
    end
  end

  assign rd_hit  = lo_sel || hi_sel;
  assign rd_byte = rd_hit ? pick_byte(count, hi_sel) : '0;

  p_stage_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr && !xfer) |=> ($stable(count) && $stable(base)));

  p_atomic_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> (count == {$past(bus_wdata), $past(stage)}) && (base == count));

  p_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count != '0) |=> (count == cnt_t'($past(count) - cnt_t'(1))));

  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (tc_o && count == base));

  p_tc_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tc_o |-> $past(wrap));

  p_write_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_wr && xfer) |=> !tc_o);
endmodule

// File: rtl/dmac_rdsel.sv
module dmac_rdsel
  import dmac_pkg::*;
#(
  parameter int N_CH = 2
) (
  input  logic [N_CH-1:0]             hit_i,
  input  logic [N_CH-1:0][BYTE_W-1:0] byte_i,
  output byte_t                       rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (hit_i[i]) rdata_o = rdata_o | byte_i[i];
    end
  end

  always_comb begin
    p_one_hit_r8: assert ($onehot0(hit_i) || $isunknown(hit_i));
  end
endmodule

// File: rtl/dma_cnt_pair.sv
module dma_cnt_pair
  import dmac_pkg::*;
#(
  parameter int                ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] PLAY_LO = 8'h0B,
  parameter logic [ADDR_W-1:0] PLAY_HI = 8'h0C,
  parameter logic [ADDR_W-1:0] REC_LO  = 8'h0D,
  parameter logic [ADDR_W-1:0] REC_HI  = 8'h0E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              play_xfer,
  input  logic              rec_xfer,
  output logic              play_tc,
  output logic              rec_tc
);
  localparam int N_CH = 2;

  logic [N_CH-1:0]             xfer_v;
  logic [N_CH-1:0]             tc_v;
  logic [N_CH-1:0]             hit_v;
  logic [N_CH-1:0][BYTE_W-1:0] byte_v;

  assign xfer_v = {rec_xfer, play_xfer};

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] LO = (g == 0) ? PLAY_LO : REC_LO;
    localparam logic [ADDR_W-1:0] HI = (g == 0) ? PLAY_HI : REC_HI;
    dmac_chan #(.ADDR_W(ADDR_W), .LO_IDX(LO), .HI_IDX(HI)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (reg_addr),
      .bus_wr    (reg_wr),
      .bus_wdata (reg_wdata),
      .xfer      (xfer_v[g]),
      .tc_o      (tc_v[g]),
      .rd_hit    (hit_v[g]),
      .rd_byte   (byte_v[g])
    );
  end

  dmac_rdsel #(.N_CH(N_CH)) u_rdsel (
    .hit_i   (hit_v),
    .byte_i  (byte_v),
    .rdata_o (reg_rdata)
  );

  assign play_tc = tc_v[0];
  assign rec_tc  = tc_v[1];

  // R7: a terminal count on one channel needs a strobe on that channel
  p_own_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    play_tc |-> $past(play_xfer));
endmodule

// File: tb/sim_dma_cnt_pair.sv
module sim_dma_cnt_pair;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       play_xfer = 1'b0, rec_xfer = 1'b0;
  logic       play_tc, rec_tc;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  dma_cnt_pair u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .play_xfer(play_xfer),
    .rec_xfer(rec_xfer), .play_tc(play_tc), .rec_tc(rec_tc)
  );

  // bench model
  logic [7:0]  idx_lo [2] = '{8'h0B, 8'h0D};
  logic [7:0]  idx_hi [2] = '{8'h0C, 8'h0E};
  logic [7:0]  m_stage [2];
  logic [15:0] m_base  [2];
  logic [15:0] m_cnt   [2];
  logic        m_tc    [2];

  function automatic logic [15:0] after_strobe(logic [15:0] c, logic [15:0] b);
    if (c == 16'h0000) return b;
    return c + 16'hFFFF;
  endfunction

  function automatic logic [7:0] exp_read(logic [7:0] a);
    for (int ch = 0; ch < 2; ch++) begin
      if (a == idx_lo[ch]) return m_cnt[ch] % 256;
      if (a == idx_hi[ch]) return m_cnt[ch] / 256;
    end
    return 8'h00;
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic read_all(input string tag);
    for (int k = 0; k < 4; k++) begin
      reg_addr = (k < 2) ? ((k == 0) ? 8'h0B : 8'h0C) : ((k == 2) ? 8'h0D : 8'h0E);
      #1;
      chk(tag, reg_rdata, exp_read(reg_addr));
    end
  endtask

  task automatic do_cycle(input logic [7:0] a, input logic w, input logic [7:0] d,
                          input logic px, input logic rx, input string tag);
    reg_addr = a; reg_wr = w; reg_wdata = d; play_xfer = px; rec_xfer = rx;
    for (int ch = 0; ch < 2; ch++) begin
      logic x;
      x = (ch == 0) ? px : rx;
      m_tc[ch] = 1'b0;
      if (w && a == idx_hi[ch]) begin
        m_base[ch] = {d, m_stage[ch]};
        m_cnt[ch]  = {d, m_stage[ch]};
      end else if (x) begin
        if (m_cnt[ch] == 16'h0000) m_tc[ch] = 1'b1;
        m_cnt[ch] = after_strobe(m_cnt[ch], m_base[ch]);
      end
      if (w && a == idx_lo[ch]) m_stage[ch] = d;
    end
    @(posedge clk);
    #1;
    reg_wr = 1'b0; play_xfer = 1'b0; rec_xfer = 1'b0;
    chk({tag, " play_tc"}, play_tc, m_tc[0]);
    chk({tag, " rec_tc"},  rec_tc,  m_tc[1]);
    read_all(tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog got=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int ch = 0; ch < 2; ch++) begin
      m_stage[ch] = 8'hFF; m_base[ch] = 16'hFFFF; m_cnt[ch] = 16'hFFFF; m_tc[ch] = 1'b0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk("R1 play_tc", play_tc, 0);
    chk("R1 rec_tc", rec_tc, 0);
    read_all("R1");
    // R2 low write only stages
    do_cycle(8'h0B, 1, 8'h34, 0, 0, "R2");
    // R3 high write loads both bytes
    do_cycle(8'h0C, 1, 8'h12, 0, 0, "R3");
    reg_addr = 8'h0B; #1 chk("R3 low", reg_rdata, 8'h34);
    // R4 decrement, R7 capture untouched
    do_cycle(8'h00, 0, 8'h00, 1, 0, "R4/R7");
    reg_addr = 8'h0E; #1 chk("R7 rec hi", reg_rdata, 8'hFF);
    // R5 wrap: load 0001, strobe twice
    do_cycle(8'h0B, 1, 8'h01, 0, 0, "R5");
    do_cycle(8'h0C, 1, 8'h00, 0, 0, "R5");
    do_cycle(8'h00, 0, 8'h00, 1, 0, "R5");
    do_cycle(8'h00, 0, 8'h00, 1, 0, "R5");
    chk("R5 pulse", play_tc, 1);
    do_cycle(8'h00, 0, 8'h00, 0, 0, "R5");
    chk("R5 single", play_tc, 0);
    // R6 high write with strobe on capture
    do_cycle(8'h0D, 1, 8'h05, 0, 0, "R6");
    do_cycle(8'h0E, 1, 8'h00, 0, 1, "R6");
    reg_addr = 8'h0D; #1 chk("R6 kept", reg_rdata, 8'h05);
    // R8 unmapped indexes
    reg_addr = 8'h0A; #1 chk("R8 0A", reg_rdata, 8'h00);
    reg_addr = 8'h0F; #1 chk("R8 0F", reg_rdata, 8'h00);
    // random mix across both channels (R7)
    void'($urandom(32'd715));
    for (int n = 0; n < 600; n++) begin
      logic [7:0] a, d;
      logic       w;
      int         r;
      r = $urandom_range(0, 9);
      w = (r < 4);
      case ($urandom_range(0, 4))
        0: a = 8'h0B; 1: a = 8'h0C; 2: a = 8'h0D; 3: a = 8'h0E; default: a = 8'h0A;
      endcase
      d = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(0, 3));
      if (a == 8'h0C || a == 8'h0E) d = ($urandom_range(0, 7) == 0) ? 8'h01 : 8'h00;
      do_cycle(a, w, d, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R7");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule